// File: doc/BRIEF.md
# Dual-Address I2C Port Expander Slave

This block is the serial front end of a sixteen-line port expander. It listens on an I2C bus and responds to two 7-bit addresses. One address reaches a bank of eight bidirectional open-drain lines. The other reaches a bank of eight push-pull outputs. Both addresses share four low bits taken from configuration straps, so sixteen expanders can sit on one bus. The two addresses differ only in their three high bits.

SCL and SDA are sampled with the system clock through a synchroniser. The block finds START and STOP conditions, shifts in the address byte with its read/write bit, and acknowledges a match by pulling SDA low through an open-drain enable. On a read it serialises response bytes. The open-drain bank sends live port levels and captured transition flags in turn. Each port byte latches the current flag byte and sends a one-cycle clear strobe to the flag logic outside the block. The push-pull bank sends the read-back levels of its outputs on every byte. Bytes written to either address are acknowledged and then discarded. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `xpdr_i2c_slave`

## Requirements
- R1: After reset `sda_oe` and `flag_clr` are 0. SCL and SDA pass through a two-stage synchroniser. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.
- R2: The first byte after START carries the address MSB first, followed by a R/W bit in bit 0 (0 = write, 1 = read). The slave acknowledges it (`sda_oe` = 1 through the 9th clock) only when the address equals {3'b110, strap_i}, which selects the open-drain bank, or {3'b101, strap_i}, which selects the push-pull bank.
- R3: For any other address the slave gives no acknowledge. It also acknowledges no later byte until the next START, even if that byte matches an address.
- R4: After a write address, each data byte the master sends is acknowledged and has no other effect. `flag_clr` does not pulse.
- R5: A read from the open-drain bank sends bytes in the order port, flags, port, flags, and so on. Each port byte is sampled from `od_port_i` when it is loaded, which is at the SCL fall that ends the preceding acknowledge clock.
- R6: Every open-drain port-byte load captures `flags_i` and pulses `flag_clr` high for exactly one clock. The flag byte that follows sends the captured value, not the live one.
- R7: Every byte of a push-pull read is `pp_port_i` sampled at its own load. `flag_clr` never pulses during such a read.
- R8: A master NACK after a read byte ends transmission. The slave keeps SDA released (reads as 0xFF) until the next START.
- R9: A START in the middle of any byte restarts address reception, and a STOP returns the slave to idle.
- R10: Read data goes out MSB first. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| sda_oe | output | 1 | 1 = pull SDA low |
| strap_i | input | 4 | Strap-selected low address bits |
| od_port_i | input | 8 | Levels of the open-drain lines |
| pp_port_i | input | 8 | Read-back levels of the push-pull outputs |
| flags_i | input | 8 | Transition flags from the port logic |
| flag_clr | output | 1 | One-cycle clear for the transition flags |

## Verification
The bench sweeps all 128 addresses for one strap setting and then tries every strap value. A decoder that compared the wrong prefix bits, or that ignored the straps, would acknowledge the wrong address. It sends a matching byte after a mismatched address with no new START. A slave that did not stay deaf would acknowledge it. Multi-byte reads change the port and flag inputs between bytes: a design that resampled flags at the flag byte would send the new value, and one that did not resample port data would repeat a stale byte. Further cases are clocking on after a NACK and cutting a byte off with a repeated START. A design that drove SDA after the NACK would corrupt the bus, and one that finished the cut-off byte would miss the new address.

// File: rtl/xpdr_pkg.sv
package xpdr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WDATA,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } xfer_state_t;

  typedef enum logic {
    BANK_OD,
    BANK_PP
  } bank_t;
endpackage

// File: rtl/xpdr_sync.sv
module xpdr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [WIDTH-1:0]             prev_q;

  // bus lines idle high, so every stage resets to ones
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= '1;
          else        pipe_q[s] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= '1;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pipe_q[STAGES-1];
  end

  assign sync_o = pipe_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/xpdr_bus_cond.sv
module xpdr_bus_cond (
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_p,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_held_high;

  always_comb begin
    scl_held_high = scl_s & scl_p;
    scl_rise      = scl_s & ~scl_p;
    scl_fall      = ~scl_s & scl_p;
    start_det     = scl_held_high & sda_p & ~sda_s;
    stop_det      = scl_held_high & ~sda_p & sda_s;
  end
endmodule

// File: rtl/xpdr_addr_match.sv
module xpdr_addr_match #(
  parameter int               PFX_W     = 3,
  parameter int               STRAP_W   = 4,
  parameter logic [PFX_W-1:0] OD_PREFIX = 3'b110,
  parameter logic [PFX_W-1:0] PP_PREFIX = 3'b101,
  localparam int              ADDR_W    = PFX_W + STRAP_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               hit_od,
  output logic               hit_pp
);
  logic low_ok;

  always_comb begin
    low_ok = (addr_i[STRAP_W-1:0] == strap_i);
    hit_od = low_ok && (addr_i[ADDR_W-1:STRAP_W] == OD_PREFIX);
    hit_pp = low_ok && (addr_i[ADDR_W-1:STRAP_W] == PP_PREFIX);
  end
endmodule

// File: rtl/xpdr_tx_src.sv
module xpdr_tx_src #(
  parameter int W = 8
) (
  input  xpdr_pkg::bank_t bank_i,
  input  logic            flag_turn_i,
  input  logic [W-1:0]    od_port_i,
  input  logic [W-1:0]    pp_port_i,
  input  logic [W-1:0]    snap_i,
  output logic [W-1:0]    byte_o,
  output logic            capture_o
);
  always_comb begin
    capture_o = 1'b0;
    if (bank_i == xpdr_pkg::BANK_PP) begin
      byte_o = pp_port_i;
    end else if (flag_turn_i) begin
      byte_o = snap_i;
    end else begin
      byte_o    = od_port_i;
      capture_o = 1'b1;
    end
  end
endmodule

// File: rtl/xpdr_i2c_slave.sv
module xpdr_i2c_slave #(
  parameter int          SYNC_STAGES = 2,
  parameter int          PFX_W       = 3,
  parameter logic [PFX_W-1:0] OD_PREFIX = 3'b110,
  parameter logic [PFX_W-1:0] PP_PREFIX = 3'b101,
  localparam int         BW          = xpdr_pkg::BYTE_W,
  localparam int         STRAP_W     = BW - 1 - PFX_W,
  localparam int         CNT_W       = $clog2(BW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BW-1:0]      od_port_i,
  input  logic [BW-1:0]      pp_port_i,
  input  logic [BW-1:0]      flags_i,
  output logic               flag_clr
);
  import xpdr_pkg::*;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BW);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // bus sampling and conditions
  logic [1:0] bus_s, bus_p;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  xpdr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .raw_i ({scl_i, sda_i}),
    .sync_o(bus_s),
    .prev_o(bus_p)
  );

  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  xpdr_bus_cond u_cond (
    .scl_s    (bus_s[1]),
    .sda_s    (bus_s[0]),
    .scl_p    (bus_p[1]),
    .sda_p    (bus_p[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  // state
  xfer_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BW-1:0]    shreg_q, shreg_d;
  logic [BW-1:0]    tx_q, tx_d;
  logic [BW-1:0]    snap_q, snap_d;
  logic             oe_q, oe_d;
  logic             rd_q, rd_d;
  logic             turn_q, turn_d;
  logic             clr_q, clr_d;
  bank_t            bank_q, bank_d;

  // address decode on the shifted byte
  logic hit_od, hit_pp;

  xpdr_addr_match #(
    .PFX_W    (PFX_W),
    .STRAP_W  (STRAP_W),
    .OD_PREFIX(OD_PREFIX),
    .PP_PREFIX(PP_PREFIX)
  ) u_match (
    .addr_i (shreg_q[BW-1:1]),
    .strap_i(strap_i),
    .hit_od (hit_od),
    .hit_pp (hit_pp)
  );

  // next response byte
  logic [BW-1:0] src_byte;
  logic          src_capture;

  xpdr_tx_src #(.W(BW)) u_src (
    .bank_i     (bank_q),
    .flag_turn_i(turn_q),
    .od_port_i  (od_port_i),
    .pp_port_i  (pp_port_i),
    .snap_i     (snap_q),
    .byte_o     (src_byte),
    .capture_o  (src_capture)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    tx_d    = tx_q;
    snap_d  = snap_q;
    oe_d    = oe_q;
    rd_d    = rd_q;
    turn_d  = turn_q;
    clr_d   = 1'b0;
    bank_d  = bank_q;

    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[BW-2:0], sda_s};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            cnt_d = '0;
            if (hit_od || hit_pp) begin
              state_d = ST_ACK;
              oe_d    = 1'b1;
              bank_d  = hit_pp ? BANK_PP : BANK_OD;
              rd_d    = shreg_q[0];
              turn_d  = 1'b0;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_q) begin
              state_d = ST_RDATA;
              tx_d    = src_byte;
              oe_d    = ~src_byte[BW-1];
              turn_d  = ~turn_q;
              if (src_capture) begin
                snap_d = flags_i;
                clr_d  = 1'b1;
              end
            end else begin
              state_d = ST_WDATA;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            cnt_d   = '0;
            oe_d    = 1'b1;
            state_d = ST_ACK;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              cnt_d   = '0;
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              tx_d = {tx_q[BW-2:0], 1'b0};
              oe_d = ~tx_q[BW-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_s) begin
            state_d = ST_SKIP;
          end else if (scl_fall) begin
            state_d = ST_RDATA;
            tx_d    = src_byte;
            oe_d    = ~src_byte[BW-1];
            turn_d  = ~turn_q;
            if (src_capture) begin
              snap_d = flags_i;
              clr_d  = 1'b1;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      snap_q  <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      turn_q  <= 1'b0;
      clr_q   <= 1'b0;
      bank_q  <= BANK_OD;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      tx_q    <= tx_d;
      snap_q  <= snap_d;
      oe_q    <= oe_d;
      rd_q    <= rd_d;
      turn_q  <= turn_d;
      clr_q   <= clr_d;
      bank_q  <= bank_d;
    end
  end

  assign sda_oe   = oe_q;
  assign flag_clr = clr_q;
endmodule

// File: rtl/xpdr_i2c_checker.sv
module xpdr_i2c_checker #(
  parameter int CNT_W = 4,
  parameter int BW    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sda_oe,
  input logic                  flag_clr,
  input logic                  scl_s,
  input xpdr_pkg::xfer_state_t state,
  input logic [CNT_W-1:0]      cnt,
  input logic                  rd,
  input xpdr_pkg::bank_t       bank
);
  import xpdr_pkg::*;

  // R3 / R8: idle or skipping means SDA stays released
  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe);

  // R4: never drive during master-written data bits
  assert_release_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WDATA) |-> !sda_oe);

  // R6: clear strobe lasts one clock
  assert_clear_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag_clr);

  // R7: clear only for open-drain reads
  assert_clear_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> (bank == BANK_OD && rd));

  // R10: drive only begins while SCL is low
  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R2: bit counter never passes one byte
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BW));
endmodule

bind xpdr_i2c_slave xpdr_i2c_checker #(.CNT_W(CNT_W), .BW(BW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sda_oe  (sda_oe),
  .flag_clr(flag_clr),
  .scl_s   (scl_s),
  .state   (state_q),
  .cnt     (cnt_q),
  .rd      (rd_q),
  .bank    (bank_q)
);

// File: tb/sim_xpdr_i2c_slave.sv
`timescale 1ns/1ps
module sim_xpdr_i2c_slave;
  localparam int Q = 8;

  logic       clk;
  logic       rst_n;
  logic       m_scl;
  logic       m_low;
  logic       sda_bus;
  logic       sda_oe;
  logic       flag_clr;
  logic [3:0] strap;
  logic [7:0] od_port, pp_port, flags;

  int checks;
  int errors;
  int clr_cnt;
  int oe_cnt;
  bit finished;

  assign sda_bus = !(m_low || sda_oe);

  xpdr_i2c_slave u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_bus),
    .sda_oe   (sda_oe),
    .strap_i  (strap),
    .od_port_i(od_port),
    .pp_port_i(pp_port),
    .flags_i  (flags),
    .flag_clr (flag_clr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (flag_clr) clr_cnt <= clr_cnt + 1;
    if (sda_oe)   oe_cnt  <= oe_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic m_start();
    m_low = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    m_low = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = !b; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      d[i] = x;
    end
    put_bit(!give_ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    int         c0, o0;
    checks = 0; errors = 0; clr_cnt = 0; oe_cnt = 0; finished = 0;
    m_scl = 1'b1; m_low = 1'b0;
    strap = 4'b1001; od_port = 8'h00; pp_port = 8'h00; flags = 8'h00;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R1 reset state
    chk("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    chk("R1 flag_clr after reset", {7'd0, flag_clr}, 8'h00);

    // R2 full address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      logic exp_ack;
      exp_ack = (a == {3'b110, strap}) || (a == {3'b101, strap});
      m_start();
      send_byte({a[6:0], 1'b0}, ack);
      chk($sformatf("R2 ack addr %02h", a), {7'd0, ack}, {7'd0, exp_ack});
      m_stop();
    end

    // R2 strap sweep: both banks hit, neighbour misses
    for (int s = 0; s < 16; s++) begin
      strap = s[3:0];
      tick(4);
      m_start(); send_byte({3'b110, s[3:0], 1'b0}, ack); m_stop();
      chk($sformatf("R2 od hit strap %0d", s), {7'd0, ack}, 8'h01);
      m_start(); send_byte({3'b101, s[3:0], 1'b0}, ack); m_stop();
      chk($sformatf("R2 pp hit strap %0d", s), {7'd0, ack}, 8'h01);
      m_start(); send_byte({3'b110, s[3:0] ^ 4'b0100, 1'b0}, ack); m_stop();
      chk($sformatf("R2 miss strap %0d", s), {7'd0, ack}, 8'h00);
    end
    strap = 4'b0110;
    tick(4);

    // R3 mismatch then a matching byte without START
    m_start();
    send_byte({3'b111, strap, 1'b0}, ack);
    chk("R3 mismatch nack", {7'd0, ack}, 8'h00);
    send_byte({3'b110, strap, 1'b0}, ack);
    chk("R3 ignored until START", {7'd0, ack}, 8'h00);
    m_stop();

    // R4 write bytes acknowledged, no flag clear
    c0 = clr_cnt;
    m_start();
    send_byte({3'b110, strap, 1'b0}, ack);
    chk("R4 write address ack", {7'd0, ack}, 8'h01);
    send_byte(8'h00, ack);
    chk("R4 data byte 0 ack", {7'd0, ack}, 8'h01);
    send_byte(8'hFF, ack);
    chk("R4 data byte 1 ack", {7'd0, ack}, 8'h01);
    m_stop();
    chk("R4 no flag clear on write", 8'(clr_cnt - c0), 8'h00);

    // R5/R6 multi-byte open-drain read with changing inputs
    od_port = 8'hA5; flags = 8'h3C;
    c0 = clr_cnt;
    m_start();
    send_byte({3'b110, strap, 1'b1}, ack);
    chk("R5 read address ack", {7'd0, ack}, 8'h01);
    recv_byte(d, 1'b1);
    chk("R5 byte0 port", d, 8'hA5);
    od_port = 8'h5A; flags = 8'h81;
    recv_byte(d, 1'b1);
    chk("R6 byte1 captured flags", d, 8'h3C);
    recv_byte(d, 1'b1);
    chk("R5 byte2 resampled port", d, 8'h5A);
    od_port = 8'h0F; flags = 8'h00;
    recv_byte(d, 1'b1);
    chk("R6 byte3 captured flags", d, 8'h81);
    recv_byte(d, 1'b0);
    chk("R5 byte4 port", d, 8'h0F);
    chk("R6 clear pulses", 8'(clr_cnt - c0), 8'h03);

    // R8 after NACK the slave stays off the bus
    o0 = oe_cnt;
    recv_byte(d, 1'b0);
    chk("R8 released after nack", d, 8'hFF);
    chk("R8 no drive after nack", 8'(oe_cnt - o0), 8'h00);
    m_stop();

    // R7 push-pull read repeats read-back
    pp_port = 8'hC3;
    c0 = clr_cnt;
    m_start();
    send_byte({3'b101, strap, 1'b1}, ack);
    chk("R7 pp address ack", {7'd0, ack}, 8'h01);
    recv_byte(d, 1'b1);
    chk("R7 pp byte0", d, 8'hC3);
    pp_port = 8'h99;
    recv_byte(d, 1'b1);
    chk("R7 pp byte1", d, 8'hC3);
    recv_byte(d, 1'b0);
    chk("R7 pp byte2 resampled", d, 8'h99);
    m_stop();
    chk("R7 no clear on pp read", 8'(clr_cnt - c0), 8'h00);

    // R10 two-byte open-drain reads over several patterns
    for (int k = 0; k < 8; k++) begin
      logic [7:0] pv, fv;
      pv = 8'(k * 37 + 1);
      fv = ~pv;
      od_port = pv; flags = fv;
      m_start();
      send_byte({3'b110, strap, 1'b1}, ack);
      recv_byte(d, 1'b1);
      chk($sformatf("R10 port pattern %0d", k), d, pv);
      recv_byte(d, 1'b0);
      chk($sformatf("R10 flag pattern %0d", k), d, fv);
      m_stop();
    end

    // R9 START in the middle of a byte restarts addressing
    od_port = 8'h6E;
    m_start();
    send_byte({3'b101, strap, 1'b0}, ack);
    chk("R9 first address ack", {7'd0, ack}, 8'h01);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    m_start();
    send_byte({3'b110, strap, 1'b1}, ack);
    chk("R9 restarted address ack", {7'd0, ack}, 8'h01);
    recv_byte(d, 1'b0);
    chk("R9 data after restart", d, 8'h6E);
    m_stop();
    tick(Q);
    chk("R9 idle after stop", {7'd0, sda_oe}, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule